// File: doc/BRIEF.md
# Dual-Clock Control and Status Register Bank

This block is a memory-mapped slave on an AXI4-Lite port. It holds three 32-bit read/write configuration words and exposes one 32-bit read-only status word. The bus side runs on `aclk`. The configuration words feed peripheral logic running on a separate clock, `mclk`. Each configuration word is re-timed into that domain through its own register chain. The status word, produced in the `mclk` domain, is re-timed into the bus domain through a chain clocked by `aclk`. A read returns the value at the end of that chain.

The bus uses valid/ready handshakes on all five channels. A transfer happens on a rising `aclk` edge where both valid and ready are high. The master may hold back any payload, and may hold back `bready` or `rready`. While it does, the block keeps the response pending and unchanged. The block can stall the master too. `awready` and `wready` drop once their channel has been captured and stay low until the write response has been taken. `arready` is low while a read response is pending.

Two single-cycle pulses run in the bus domain. One marks each accepted write to the control word. The other marks each read of the status word. The intended field meanings are these. In the control word, bit 0 is an enable, bit 1 is an output polarity and bits 7:4 are a prescaler. In the status word, bit 0 reports activity and bit 1 reports a held fault. The bank stores and passes these fields without acting on them.

Top module: `cdc_regbank`

## Requirements
- R1: Address decode uses bits 3:2 as the word index and ignores bits 1:0. An address is in range only when every bit above bit 3 is zero. The indices are 0 = control, 1 = period, 2 = duty (all read/write) and 3 = status (read-only).
- R2: A write to a read/write word completes with response 2'b00 (OKAY). A later read of that word returns the stored value, also with OKAY.
- R3: Write strobe bit i enables byte i (bits 8i+7:8i). Bytes whose strobe is 0 keep their old value, and an all-zero strobe changes nothing.
- R4: A write to the status word (offset 0x0C) changes no stored state and completes with response 2'b10 (SLVERR).
- R5: Any access at an out-of-range address gets SLVERR. A read of such an address returns zero data, and a write to it leaves every register unchanged.
- R6: The write address and write data channels may complete in either order. The write response appears only after both have been accepted. While the response is pending, `awready` and `wready` are low, so at most one write is outstanding.
- R7: Once raised, `bvalid` and `rvalid` stay high, with their response and data unchanged, until the matching ready is high at a clock edge.
- R8: `ctrl_wr_pulse` is high for exactly one `aclk` cycle for each accepted write to the control word. It coincides with the first cycle of that write's OKAY response, and no other access raises it.
- R9: `stat_rd_pulse` is high for exactly one `aclk` cycle for each read of the status word. It coincides with the first cycle of that read's OKAY response, and no other access raises it.
- R10: Each read/write word reaches its `cfg_*` output through SYNC_STAGES registers clocked by `mclk`. The output keeps its old value until SYNC_STAGES `mclk` edges have passed after the write.
- R11: `stat_in` passes through SYNC_STAGES registers clocked by `aclk`, and a status read returns the last stage.
- R12: When `aresetn` is low, every stored word, every stage of both synchronizer chains, both valids and both pulses clear at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Bus-domain clock |
| aresetn | input | 1 | Active-low asynchronous reset for both domains |
| mclk | input | 1 | Module-domain clock |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write byte address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte enables |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read byte address |
| rvalid | output | 1 | Read response valid |
| rready | input | 1 | Read response ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| stat_in | input | DATA_W | Status word from the module domain |
| cfg_ctrl | output | DATA_W | Control word, module domain |
| cfg_period | output | DATA_W | Period word, module domain |
| cfg_duty | output | DATA_W | Duty word, module domain |
| ctrl_wr_pulse | output | 1 | One-cycle pulse on each write to the control word |
| stat_rd_pulse | output | 1 | One-cycle pulse on each read of the status word |

## Verification
The bench uses the defaults: ADDR_W = 8, DATA_W = 32, SYNC_STAGES = 2. The 8-bit address gives it the offsets 0x10 to 0xFC to probe the out-of-range error path and to check that those writes do not alias onto the real words. Two stages, with an `mclk` slower than `aclk`, leave a window in which the bench sees that a new configuration value has not yet reached its `cfg_*` output, and then sees it arrive once the chain has settled.

// File: rtl/cdc_regbank_pkg.sv
package cdc_regbank_pkg;
  // Register map shape
  localparam int REG_COUNT     = 4;
  localparam int IDX_W         = $clog2(REG_COUNT);
  localparam int RO_IDX        = 3;   // status word
  localparam int WR_STROBE_IDX = 0;   // control word
  localparam int RD_STROBE_IDX = 3;   // status word

  // Response codes
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/regbank_sync.sv
module regbank_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/regbank_wr.sv
module regbank_wr
  import cdc_regbank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int RW_COUNT = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             awvalid,
  output logic                             awready,
  input  logic [ADDR_W-1:0]                awaddr,
  input  logic                             wvalid,
  output logic                             wready,
  input  logic [DATA_W-1:0]                wdata,
  input  logic [DATA_W/8-1:0]              wstrb,
  output logic                             bvalid,
  input  logic                             bready,
  output logic [1:0]                       bresp,
  output logic [RW_COUNT-1:0][DATA_W-1:0]  rw_q,
  output logic                             wr_pulse
);
  localparam int LANES = DATA_W / 8;

  logic                aw_held;
  logic                w_held;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q;
  logic [LANES-1:0]    strb_q;
  logic [IDX_W-1:0]    idx;
  logic                in_range;
  logic                rw_hit;
  logic                commit;

  assign awready  = !aw_held && !bvalid;
  assign wready   = !w_held  && !bvalid;
  assign idx      = addr_q[IDX_W+1:2];
  assign in_range = (addr_q[ADDR_W-1:IDX_W+2] == '0);
  assign rw_hit   = in_range && (idx != IDX_W'(RO_IDX));
  assign commit   = aw_held && w_held && !bvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_held  <= 1'b0;
      w_held   <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      strb_q   <= '0;
      bvalid   <= 1'b0;
      bresp    <= RESP_OKAY;
      rw_q     <= '0;
      wr_pulse <= 1'b0;
    end else begin
      wr_pulse <= 1'b0;
      if (awvalid && awready) begin
        aw_held <= 1'b1;
        addr_q  <= awaddr;
      end
      if (wvalid && wready) begin
        w_held <= 1'b1;
        data_q <= wdata;
        strb_q <= wstrb;
      end
      if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
      if (commit) begin
        aw_held  <= 1'b0;
        w_held   <= 1'b0;
        bvalid   <= 1'b1;
        bresp    <= rw_hit ? RESP_OKAY : RESP_SLVERR;
        wr_pulse <= rw_hit && (idx == IDX_W'(WR_STROBE_IDX));
        for (int r = 0; r < RW_COUNT; r++) begin
          if (rw_hit && (idx == IDX_W'(r))) begin
            for (int b = 0; b < LANES; b++) begin
              if (strb_q[b]) begin
                rw_q[r][b*8 +: 8] <= data_q[b*8 +: 8];
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/regbank_rd.sv
module regbank_rd
  import cdc_regbank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int RW_COUNT = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             arvalid,
  output logic                             arready,
  input  logic [ADDR_W-1:0]                araddr,
  output logic                             rvalid,
  input  logic                             rready,
  output logic [DATA_W-1:0]                rdata,
  output logic [1:0]                       rresp,
  input  logic [RW_COUNT-1:0][DATA_W-1:0]  rw_q,
  input  logic [DATA_W-1:0]                stat_q,
  output logic                             rd_pulse
);
  logic [IDX_W-1:0]  idx;
  logic              in_range;
  logic [DATA_W-1:0] sel;

  assign arready  = !rvalid;
  assign idx      = araddr[IDX_W+1:2];
  assign in_range = (araddr[ADDR_W-1:IDX_W+2] == '0);

  always_comb begin
    sel = '0;
    if (in_range) begin
      if (idx == IDX_W'(RO_IDX)) begin
        sel = stat_q;
      end
      for (int r = 0; r < RW_COUNT; r++) begin
        if (idx == IDX_W'(r)) begin
          sel = rw_q[r];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid   <= 1'b0;
      rdata    <= '0;
      rresp    <= RESP_OKAY;
      rd_pulse <= 1'b0;
    end else begin
      rd_pulse <= 1'b0;
      if (rvalid && rready) begin
        rvalid <= 1'b0;
      end
      if (arvalid && arready) begin
        rvalid   <= 1'b1;
        rdata    <= sel;
        rresp    <= in_range ? RESP_OKAY : RESP_SLVERR;
        rd_pulse <= in_range && (idx == IDX_W'(RD_STROBE_IDX));
      end
    end
  end
endmodule

// File: rtl/cdc_regbank.sv
module cdc_regbank
  import cdc_regbank_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                aclk,
  input  logic                aresetn,
  input  logic                mclk,
  input  logic                awvalid,
  output logic                awready,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic                wvalid,
  output logic                wready,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  output logic                bvalid,
  input  logic                bready,
  output logic [1:0]          bresp,
  input  logic                arvalid,
  output logic                arready,
  input  logic [ADDR_W-1:0]   araddr,
  output logic                rvalid,
  input  logic                rready,
  output logic [DATA_W-1:0]   rdata,
  output logic [1:0]          rresp,
  input  logic [DATA_W-1:0]   stat_in,
  output logic [DATA_W-1:0]   cfg_ctrl,
  output logic [DATA_W-1:0]   cfg_period,
  output logic [DATA_W-1:0]   cfg_duty,
  output logic                ctrl_wr_pulse,
  output logic                stat_rd_pulse
);
  localparam int RW_COUNT = REG_COUNT - 1;

  logic [RW_COUNT-1:0][DATA_W-1:0] rw_q;
  logic [RW_COUNT-1:0][DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0]               stat_q;

  regbank_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RW_COUNT(RW_COUNT)) u_wr (
    .clk(aclk), .rst_n(aresetn),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .rw_q(rw_q), .wr_pulse(ctrl_wr_pulse)
  );

  regbank_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RW_COUNT(RW_COUNT)) u_rd (
    .clk(aclk), .rst_n(aresetn),
    .arvalid(arvalid), .arready(arready), .araddr(araddr),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
    .rw_q(rw_q), .stat_q(stat_q), .rd_pulse(stat_rd_pulse)
  );

  // Bus domain -> module domain, one chain per read/write word
  for (genvar g = 0; g < RW_COUNT; g++) begin : g_out_sync
    regbank_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(mclk), .arst_n(aresetn), .d(rw_q[g]), .q(cfg_q[g])
    );
  end

  // Module domain -> bus domain, status word
  regbank_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_stat_sync (
    .clk(aclk), .arst_n(aresetn), .d(stat_in), .q(stat_q)
  );

  assign cfg_ctrl   = cfg_q[0];
  assign cfg_period = cfg_q[1];
  assign cfg_duty   = cfg_q[2];
endmodule

// File: rtl/cdc_regbank_chk.sv
module cdc_regbank_chk
  import cdc_regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              aclk,
  input logic              aresetn,
  input logic              awready,
  input logic              wready,
  input logic              bvalid,
  input logic              bready,
  input logic [1:0]        bresp,
  input logic              rvalid,
  input logic              rready,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        rresp,
  input logic              ctrl_wr_pulse,
  input logic              stat_rd_pulse
);
  a_r7_bresp_hold: assert property (@(posedge aclk) disable iff (!aresetn)
    bvalid && !bready |=> bvalid && $stable(bresp));

  a_r7_rdata_hold: assert property (@(posedge aclk) disable iff (!aresetn)
    rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rresp));

  a_r6_single_outstanding: assert property (@(posedge aclk) disable iff (!aresetn)
    bvalid |-> !awready && !wready);

  a_r8_wr_pulse_width: assert property (@(posedge aclk) disable iff (!aresetn)
    ctrl_wr_pulse |=> !ctrl_wr_pulse);

  a_r8_wr_pulse_okay: assert property (@(posedge aclk) disable iff (!aresetn)
    ctrl_wr_pulse |-> bvalid && (bresp == RESP_OKAY));

  a_r9_rd_pulse_width: assert property (@(posedge aclk) disable iff (!aresetn)
    stat_rd_pulse |=> !stat_rd_pulse);

  a_r9_rd_pulse_okay: assert property (@(posedge aclk) disable iff (!aresetn)
    stat_rd_pulse |-> rvalid && (rresp == RESP_OKAY));

  a_r5_error_read_zero: assert property (@(posedge aclk) disable iff (!aresetn)
    rvalid && (rresp == RESP_SLVERR) |-> rdata == '0);
endmodule

bind cdc_regbank cdc_regbank_chk #(.DATA_W(DATA_W)) u_chk (
  .aclk(aclk), .aresetn(aresetn), .awready(awready), .wready(wready),
  .bvalid(bvalid), .bready(bready), .bresp(bresp),
  .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
  .ctrl_wr_pulse(ctrl_wr_pulse), .stat_rd_pulse(stat_rd_pulse)
);

// File: tb/cdc_regbank_test.sv
`timescale 1ns/1ps
module cdc_regbank_test;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int STAGES = 2;
  localparam int NV     = 17;

  logic aclk = 1'b0, mclk = 1'b0, aresetn = 1'b0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
  logic [DATA_W-1:0] wdata = '0, stat_in = '0;
  logic [3:0] wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [DATA_W-1:0] rdata, cfg_ctrl, cfg_period, cfg_duty;
  logic ctrl_wr_pulse, stat_rd_pulse;

  int checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0;
  bit done = 0, b_drop = 0, busy_bad = 0, r_drop = 0;
  logic [DATA_W-1:0] snap_period;

  always #2.5 aclk = ~aclk;
  initial begin #1.2; forever #3.5 mclk = ~mclk; end

  cdc_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(STAGES)) uut (
    .aclk(aclk), .aresetn(aresetn), .mclk(mclk),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .araddr(araddr),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
    .stat_in(stat_in), .cfg_ctrl(cfg_ctrl), .cfg_period(cfg_period), .cfg_duty(cfg_duty),
    .ctrl_wr_pulse(ctrl_wr_pulse), .stat_rd_pulse(stat_rd_pulse)
  );

  always @(negedge aclk) if (aresetn) begin
    if (ctrl_wr_pulse) wr_cnt++;
    if (stat_rd_pulse) rd_cnt++;
  end

  // {wr, addr, data, strb, resp, rdata}
  localparam logic [78:0] VECS [NV] = '{
    {1'b1, 8'h00, 32'hA5A5_00F1, 4'hF, 2'b00, 32'h0},
    {1'b0, 8'h00, 32'h0,         4'h0, 2'b00, 32'hA5A5_00F1},
    {1'b1, 8'h04, 32'h1234_5678, 4'hF, 2'b00, 32'h0},
    {1'b1, 8'h08, 32'hCAFE_BABE, 4'hF, 2'b00, 32'h0},
    {1'b1, 8'h04, 32'hFFFF_FFFF, 4'h5, 2'b00, 32'h0},
    {1'b0, 8'h04, 32'h0,         4'h0, 2'b00, 32'h12FF_56FF},
    {1'b1, 8'h0C, 32'hDEAD_BEEF, 4'hF, 2'b10, 32'h0},
    {1'b0, 8'h0C, 32'h0,         4'h0, 2'b00, 32'h0},
    {1'b1, 8'h10, 32'h1111_1111, 4'hF, 2'b10, 32'h0},
    {1'b0, 8'h00, 32'h0,         4'h0, 2'b00, 32'hA5A5_00F1},
    {1'b0, 8'h10, 32'h0,         4'h0, 2'b10, 32'h0},
    {1'b0, 8'hFC, 32'h0,         4'h0, 2'b10, 32'h0},
    {1'b1, 8'h0A, 32'h0000_0001, 4'h1, 2'b00, 32'h0},
    {1'b0, 8'h0B, 32'h0,         4'h0, 2'b00, 32'hCAFE_BA01},
    {1'b1, 8'h08, 32'hFFFF_FFFF, 4'h0, 2'b00, 32'h0},
    {1'b0, 8'h08, 32'h0,         4'h0, 2'b00, 32'hCAFE_BA01},
    {1'b0, 8'h04, 32'h0,         4'h0, 2'b00, 32'h12FF_56FF}
  };
  localparam string TAGS [NV] = '{"R2", "R2", "R2", "R2", "R3", "R3", "R4", "R4",
    "R5", "R5", "R5", "R5", "R1", "R1", "R3", "R3", "R2"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int aw_lag, input int w_lag, input int b_lag,
                          output logic [1:0] resp);
    bit aw_d = 0, w_d = 0, aw_acc, w_acc;
    int cyc = 0;
    @(negedge aclk);
    while (!(aw_d && w_d)) begin
      if (!aw_d && cyc >= aw_lag) begin awvalid = 1; awaddr = a; end
      if (!w_d && cyc >= w_lag) begin wvalid = 1; wdata = d; wstrb = s; end
      aw_acc = awvalid && awready;
      w_acc  = wvalid && wready;
      @(negedge aclk);
      cyc++;
      if (aw_acc) begin awvalid = 0; aw_d = 1; end
      if (w_acc) begin wvalid = 0; w_d = 1; end
    end
    while (!bvalid) @(negedge aclk);
    snap_period = cfg_period;
    resp = bresp;
    for (int i = 0; i < b_lag; i++) begin
      @(negedge aclk);
      if (!bvalid || bresp !== resp) b_drop = 1;
      if (awready || wready) busy_bad = 1;
    end
    bready = 1;
    @(negedge aclk);
    bready = 0;
  endtask

  task automatic do_read(input logic [7:0] a, input int r_lag,
                         output logic [31:0] data, output logic [1:0] resp);
    bit acc;
    @(negedge aclk);
    arvalid = 1; araddr = a;
    forever begin
      acc = arready;
      @(negedge aclk);
      if (acc) begin arvalid = 0; break; end
    end
    while (!rvalid) @(negedge aclk);
    data = rdata; resp = rresp;
    for (int i = 0; i < r_lag; i++) begin
      @(negedge aclk);
      if (!rvalid || rdata !== data || rresp !== resp) r_drop = 1;
    end
    rready = 1;
    @(negedge aclk);
    rready = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge aclk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [1:0] resp;
    logic [31:0] data;
    int wc0, rc0;
    repeat (3) @(negedge aclk);
    aresetn = 1;
    @(negedge aclk);
    // R12: state after reset
    check("R12 ready lines", {29'b0, awready, wready, arready}, 32'h7);
    check("R12 valids", {30'b0, bvalid, rvalid}, 32'h0);
    check("R12 cfg_ctrl", cfg_ctrl, 32'h0);
    check("R12 cfg_duty", cfg_duty, 32'h0);
    check("R12 pulses", {30'b0, ctrl_wr_pulse, stat_rd_pulse}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [78:0] v = VECS[i];
      logic [7:0] a = v[77:70];
      bit exp_wp = v[78] && a[7:4] == 0 && a[3:2] == 2'd0;
      bit exp_rp = !v[78] && a[7:4] == 0 && a[3:2] == 2'd3;
      wc0 = wr_cnt; rc0 = rd_cnt;
      if (v[78]) begin
        do_write(a, v[69:38], v[37:34], 0, 0, 0, resp);
        check({TAGS[i], " write resp"}, {30'b0, resp}, {30'b0, v[33:32]});
      end else begin
        do_read(a, 0, data, resp);
        check({TAGS[i], " read resp"}, {30'b0, resp}, {30'b0, v[33:32]});
        check({TAGS[i], " read data"}, data, v[31:0]);
      end
      check("R8 write pulse count", wr_cnt - wc0, {31'b0, exp_wp});
      check("R9 read pulse count", rd_cnt - rc0, {31'b0, exp_rp});
    end

    // R6: data before address, then address before data
    do_write(8'h00, 32'h0000_0073, 4'hF, 3, 0, 0, resp);
    check("R6 w-first resp", {30'b0, resp}, 32'h0);
    do_read(8'h00, 0, data, resp);
    check("R6 w-first data", data, 32'h0000_0073);
    do_write(8'h04, 32'h0000_0100, 4'hF, 0, 4, 0, resp);
    check("R6 aw-first resp", {30'b0, resp}, 32'h0);
    do_read(8'h04, 0, data, resp);
    check("R6 aw-first data", data, 32'h0000_0100);

    // R7 / R6: responses held under back-pressure
    do_write(8'h08, 32'h0000_0055, 4'hF, 0, 0, 4, resp);
    check("R7 bvalid held", {31'b0, b_drop}, 32'h0);
    check("R6 no second write accepted", {31'b0, busy_bad}, 32'h0);
    do_read(8'h08, 5, data, resp);
    check("R7 rvalid held", {31'b0, r_drop}, 32'h0);
    check("R7 read data", data, 32'h0000_0055);

    // R10: module-domain outputs lag by the chain
    do_write(8'h04, 32'hA0A0_0001, 4'hF, 0, 0, 0, resp);
    check("R10 not yet visible", snap_period, 32'h0000_0100);
    repeat (STAGES + 1) @(posedge mclk);
    #1;
    check("R10 cfg_period", cfg_period, 32'hA0A0_0001);
    check("R10 cfg_ctrl", cfg_ctrl, 32'h0000_0073);
    check("R10 cfg_duty", cfg_duty, 32'h0000_0055);

    // R11 / R9: status crossing and read pulse
    @(negedge mclk);
    stat_in = 32'h0000_0003;
    repeat (STAGES + 2) @(negedge aclk);
    rc0 = rd_cnt;
    do_read(8'h0C, 0, data, resp);
    check("R11 status value", data, 32'h0000_0003);
    check("R9 status read pulse", rd_cnt - rc0, 32'h1);

    // R12: asynchronous reset mid-run
    #1.3;
    aresetn = 0;
    #0.5;
    check("R12 async cfg_period", cfg_period, 32'h0);
    check("R12 async cfg_ctrl", cfg_ctrl, 32'h0);
    @(negedge aclk);
    aresetn = 1;
    do_read(8'h04, 0, data, resp);
    check("R12 stored word cleared", data, 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule